// File: doc/BRIEF.md
# Two-Tone Coupled Audio Timer Pair

This block holds two down-counting tone timers, channel A and channel B, each loaded from its own programmable period value. Both advance only on a clock-enable tick. When a timer is at zero on a tick it underruns. It then emits a one-cycle underrun pulse, reloads its period and flips its square-wave output. A timer with period value P therefore underruns once every P+1 ticks.

In two-tone mode the timers are coupled in one direction only. An underrun of channel B always reloads channel A without any output from A. An underrun of channel A reloads channel B the same way, but only while the effective serial bit is 1. The effective serial bit is the serial data input, forced to 0 whenever the force-space control is set. The serial bit selects no channel. It only changes how the two timers are kept in step. Channel B is normally given the longer period. A restart strobe reloads both timers at once. A period value written without a restart takes effect at the next reload.

Top module: `tone_pair_timers`

## Requirements
- R1: After reset both counts are 0, both underrun pulses are low and both square outputs are low.
- R2: Each count decreases by one on each tick at which it is non-zero and holds without a tick. On a tick at which the count is 0, the timer underruns and reloads its period value. The underrun pulse is high for exactly the one clock cycle after that tick, so a period value P gives one underrun every P+1 ticks.
- R3: Each underrun flips that channel's square output. Silent reloads caused by coupling or restart leave it unchanged.
- R4: With two-tone mode off, each channel runs on its own period, whatever the serial and force-space inputs are.
- R5: With two-tone mode on, every underrun of channel B reloads channel A with its period value, with no pulse and no toggle on A.
- R6: With two-tone mode on and an effective serial bit of 1, an underrun of channel A reloads channel B silently. With an effective serial bit of 0 it does not.
- R7: While force-space is 1 the effective serial bit is 0, so channel A never reloads channel B and channel B keeps its own period.
- R8: The restart strobe reloads both counts from their period values, takes priority over a tick in the same cycle, and produces no underrun pulse.
- R9: Changing a period value without a restart leaves the running count untouched. The new value is used at the next reload.
- R10: With two-tone mode on, if both counts are 0 on the same tick, only channel B underruns. Channel A is reloaded silently, with no pulse and no toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable that advances both timers |
| restart | input | 1 | Reloads both timers from their period values |
| two_tone | input | 1 | Enables coupling between the channels |
| ser_bit | input | 1 | Serial output line |
| force_space | input | 1 | Holds the effective serial bit at 0 |
| period_a | input | CNT_W | Period value of channel A |
| period_b | input | CNT_W | Period value of channel B |
| uflow_a | output | 1 | Underrun pulse of channel A |
| uflow_b | output | 1 | Underrun pulse of channel B |
| sq_a | output | 1 | Square output of channel A |
| sq_b | output | 1 | Square output of channel B |

## Verification
The bench builds the block with the default 8-bit counters and drives only period values from 0 to 4. At that size every pairing of the two periods is reachable under every setting of two-tone mode, serial bit and force-space, each within a few dozen ticks. This brings both coupling directions, the simultaneous-zero case and zero-length periods within reach of a full sweep. Directed runs count underruns over fixed tick windows to check the period arithmetic, period changes in mid-count and restarts that coincide with ticks.

// File: rtl/tt_pkg.sv
package tt_pkg;
  // next count of a free-running timer on a tick
  function automatic logic [15:0] next_count(input logic [15:0] cur,
                                             input logic [15:0] period);
    return (cur == '0) ? period : cur - 16'd1;
  endfunction

  // serial bit as seen by the coupling
  function automatic logic eff_serial(input logic ser, input logic force_sp);
    return ser & ~force_sp;
  endfunction
endpackage

// File: rtl/tt_down_timer.sv
module tt_down_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_now,
  input  logic [CNT_W-1:0] period,
  output logic             at_zero
);
  import tt_pkg::*;
  logic [CNT_W-1:0] count;
  logic [15:0]      nxt_wide;

  assign nxt_wide = next_count(16'(count), 16'(period));
  assign at_zero  = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (load_now) count <= period;
    else if (tick)     count <= nxt_wide[CNT_W-1:0];
  end

  // R8
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> count == $past(period));
  // R2
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_now && count != '0) |=> count == $past(count) - 1'b1);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_now) |=> $stable(count));
endmodule

// File: rtl/tt_coupler.sv
module tt_coupler (
  input  logic tick,
  input  logic restart,
  input  logic two_tone,
  input  logic ser_bit,
  input  logic force_space,
  input  logic zero_a,
  input  logic zero_b,
  output logic ev_a,
  output logic ev_b,
  output logic sync_a,
  output logic sync_b
);
  import tt_pkg::*;
  logic ser_eff;
  logic live;

  assign ser_eff = eff_serial(ser_bit, force_space);
  assign live    = tick & ~restart;
  // B has priority when both reach zero together in coupled mode
  assign ev_b    = live & zero_b;
  assign ev_a    = live & zero_a & ~(two_tone & zero_b);
  assign sync_a  = two_tone & ev_b;
  assign sync_b  = two_tone & ev_a & ser_eff;

  // R10
  single_event_chk: assert final (!(two_tone && ev_a && ev_b));
  // R6
  sync_excl_chk: assert final (!(sync_a && sync_b));
endmodule

// File: rtl/tt_tone_out.sv
module tt_tone_out (
  input  logic clk,
  input  logic rst_n,
  input  logic event_in,
  output logic uflow,
  output logic sq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uflow <= 1'b0;
      sq    <= 1'b0;
    end else begin
      uflow <= event_in;
      if (event_in) sq <= ~sq;
    end
  end

  // R3
  toggle_on_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |-> sq != $past(sq));
  // R3
  hold_no_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uflow |-> $stable(sq));
endmodule

// File: rtl/tone_pair_timers.sv
module tone_pair_timers #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             two_tone,
  input  logic             ser_bit,
  input  logic             force_space,
  input  logic [CNT_W-1:0] period_a,
  input  logic [CNT_W-1:0] period_b,
  output logic             uflow_a,
  output logic             uflow_b,
  output logic             sq_a,
  output logic             sq_b
);
  localparam int NCH = 2;

  logic [NCH-1:0]   zero_v, ev_v, sync_v, load_v, uflow_v, sq_v;
  logic [CNT_W-1:0] period_v [NCH];

  assign period_v[0] = period_a;
  assign period_v[1] = period_b;

  tt_coupler u_couple (
    .tick(tick), .restart(restart), .two_tone(two_tone),
    .ser_bit(ser_bit), .force_space(force_space),
    .zero_a(zero_v[0]), .zero_b(zero_v[1]),
    .ev_a(ev_v[0]), .ev_b(ev_v[1]),
    .sync_a(sync_v[0]), .sync_b(sync_v[1])
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign load_v[ch] = restart | sync_v[ch];

    tt_down_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load_now(load_v[ch]),
      .period(period_v[ch]), .at_zero(zero_v[ch])
    );

    tt_tone_out u_out (
      .clk(clk), .rst_n(rst_n), .event_in(ev_v[ch]),
      .uflow(uflow_v[ch]), .sq(sq_v[ch])
    );
  end

  assign uflow_a = uflow_v[0];
  assign uflow_b = uflow_v[1];
  assign sq_a    = sq_v[0];
  assign sq_b    = sq_v[1];

  // R8
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !uflow_a && !uflow_b);
  // R2
  no_tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !uflow_a && !uflow_b);
  // R7
  force_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (two_tone && force_space && tick && !restart && zero_v[1]) |=> uflow_b);
endmodule

// File: tb/tone_pair_timers_test.sv
module tone_pair_timers_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, restart = 1'b0, two_tone = 1'b0, ser_bit = 1'b0, force_space = 1'b0;
  logic [W-1:0] period_a = '0, period_b = '0;
  logic uflow_a, uflow_b, sq_a, sq_b;

  int checks = 0, fails = 0;
  int ma = 0, mb = 0;
  logic eua = 0, eub = 0, esa = 0, esb = 0;
  int cnt_a = 0, cnt_b = 0;

  always #10 clk = ~clk;

  tone_pair_timers #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
    .two_tone(two_tone), .ser_bit(ser_bit), .force_space(force_space),
    .period_a(period_a), .period_b(period_b),
    .uflow_a(uflow_a), .uflow_b(uflow_b), .sq_a(sq_a), .sq_b(sq_b)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // expected behaviour after one clock with the given inputs
  task automatic model_edge(input logic t, input logic r);
    bit za, zb, ea, eb, es;
    if (r) begin
      ma = period_a; mb = period_b; eua = 0; eub = 0;
    end else if (t) begin
      za = (ma == 0); zb = (mb == 0);
      es = ser_bit && !force_space;
      eb = zb;
      ea = za && !(two_tone && zb);
      if (two_tone && eb)           ma = period_a;
      else                          ma = za ? int'(period_a) : ma - 1;
      if (zb || (two_tone && ea && es)) mb = period_b;
      else                          mb = mb - 1;
      eua = ea; eub = eb;
      if (ea) esa = ~esa;
      if (eb) esb = ~esb;
    end else begin
      eua = 0; eub = 0;
    end
  endtask

  task automatic step(input logic t, input logic r, input string tag);
    tick = t; restart = r;
    @(posedge clk);
    model_edge(t, r);
    @(negedge clk);
    chk(tag, "uflow_a", uflow_a, eua);
    chk(tag, "uflow_b", uflow_b, eub);
    chk(tag, "sq_a", sq_a, esa);
    chk(tag, "sq_b", sq_b, esb);
    cnt_a += uflow_a; cnt_b += uflow_b;
    tick = 0; restart = 0;
  endtask

  initial begin
    #4000000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "uflow_a", uflow_a, 0); chk("R1", "uflow_b", uflow_b, 0);
    chk("R1", "sq_a", sq_a, 0);       chk("R1", "sq_b", sq_b, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: zero counts underrun on first tick
    step(1, 0, "R1");
    chk("R1", "first tick underruns A", uflow_a, 1);

    // R2 / R4: independent periods, count underruns
    two_tone = 0; period_a = 2; period_b = 4;
    step(0, 1, "R8");
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 30; i++) step(1, 0, "R4");
    chk("R2", "A underruns in 30 ticks", cnt_a, 30 / 3);
    chk("R4", "B underruns in 30 ticks", cnt_b, 30 / 5);
    // R2: no tick, no underrun
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 10; i++) step(0, 0, "R2");
    chk("R2", "no underrun without tick", cnt_a + cnt_b, 0);

    // R9: period change mid-count
    period_a = 3; step(0, 1, "R9");
    step(1, 0, "R9"); step(1, 0, "R9");
    period_a = 0;
    cnt_a = 0;
    step(1, 0, "R9");
    chk("R9", "old count still running", uflow_a, 0);
    step(1, 0, "R9");
    chk("R9", "underrun at old schedule", uflow_a, 1);
    step(1, 0, "R9");
    chk("R9", "new zero period applies", uflow_a, 1);

    // R8: restart together with tick suppresses underrun
    step(1, 1, "R8");
    chk("R8", "restart overrides tick", uflow_a + uflow_b, 0);

    // R10: both equal periods in two-tone
    two_tone = 1; ser_bit = 0; force_space = 0; period_a = 2; period_b = 2;
    step(0, 1, "R10");
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 9; i++) step(1, 0, "R10");
    chk("R10", "A silent on shared zero", cnt_a, 0);
    chk("R10", "B underruns", cnt_b, 3);

    // R6: A resets B when serial high
    period_a = 1; period_b = 3; ser_bit = 1; force_space = 0;
    step(0, 1, "R6");
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 8; i++) step(1, 0, "R6");
    chk("R6", "B held off by A", cnt_b, 0);
    chk("R6", "A underruns", cnt_a, 4);
    // R7: force-space blocks A->B coupling
    force_space = 1;
    step(0, 1, "R7");
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 8; i++) step(1, 0, "R7");
    chk("R7", "B keeps own period", cnt_b, 2);
    // R5: A is reset by B (A period 1, B period 3): A underruns once per B cycle
    chk("R5", "A pulses reduced by B resets", cnt_a, 2);

    // sweep over small configurations
    for (int tt = 0; tt < 2; tt++)
      for (int sb = 0; sb < 2; sb++)
        for (int fs = 0; fs < 2; fs++)
          for (int pa = 0; pa < 5; pa++)
            for (int pb = 0; pb < 5; pb++) begin
              two_tone = tt[0]; ser_bit = sb[0]; force_space = fs[0];
              period_a = W'(pa); period_b = W'(pb);
              step(0, 1, "R8");
              for (int k = 0; k < 24; k++) begin
                if (k == 12) ser_bit = ~ser_bit;
                step((k % 5) != 3, 0, tt ? (fs ? "R7" : "R6") : "R4");
              end
            end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule